// File: doc/BRIEF.md
# Reset Cause Register

This block keeps a record of why the system last came out of reset and lets the host read that record as one 8-bit register on a simple register bus. Five causes are tracked:
- a cold power-on;
- a reset ordered by the management controller;
- a front-panel push-button reset;
- a reset arriving on the backplane reset line;
- a watchdog expiry.

The four non-power-on causes arrive as asynchronous levels or pulses. They are synchronised into the register clock and edge-detected, so one event raises its flag exactly once. Software clears flags by writing ones to them.

The contents survive a warm system reset and return to their defaults only on power-on. Power-on itself marks the cold-start flag. One further bit is an ordinary firmware-owned flag. Firmware sets it to tell the management controller not to log the next reset.

Top module: `rst_cause_reg`

## Requirements
- R1: A read at address 0x285 returns the register contents on `bus_rdata` one clock after the address is presented. A read at any other address returns 0 and leaves the register unchanged.
- R2: After power-on reset (`por_rst` high), the register reads 0x80: bit 7 is 1 and every other bit is 0.
- R3: Bit 7 (cold start) is cleared by writing 1 to it at 0x285. No source event and no write can set it; only power-on sets it.
- R4: Source flags sit at bit 3 (management controller), bit 2 (front panel), bit 1 (backplane) and bit 0 (watchdog). A rising edge on a source input sets its flag on the third clock edge after the input rises. A level held high sets the flag only once.
- R5: Writing 1 to any of bits 3..0 at 0x285 clears that flag. Several flags can be cleared in one write, and writing 0 to a flag leaves it unchanged.
- R6: When a source sets a flag in the same cycle as a write of 1 clears it, the flag ends up set.
- R7: Bit 5 (suppress logging of the next reset) takes the written value on every write to 0x285 and defaults to 0.
- R8: Bits 6 and 4 always read 0 and ignore written values.
- R9: A warm reset (`warm_rst` high) leaves all flags unchanged. The read data register outputs 0 on the following cycle.
- R10: Writes to any address other than 0x285 leave the register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| por_rst | input | 1 | Power-on reset, synchronous active-high; also marks cold start |
| warm_rst | input | 1 | Warm system reset; clears only the read data register |
| evt_mgmt | input | 1 | Management-controller reset event (asynchronous) |
| evt_panel | input | 1 | Front-panel button reset event (asynchronous) |
| evt_bkpl | input | 1 | Backplane reset input event (asynchronous) |
| evt_wdog | input | 1 | Watchdog timeout event (asynchronous) |
| bus_addr | input | 12 | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
The hardest case to reach is the collision between a source event and a clear of the same flag. The internal set pulse exists for a single cycle, two synchronizer stages after the input rises, and a write of 1 must land on exactly that clock edge. The stimulus raises the management-controller input, waits two edges, and then presents the clearing write on the third edge. The flag must still read set afterwards. A held-high input is also cleared while it stays high, which shows that a level is not taken as a fresh event.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
    localparam int ADDR_W    = 12;
    localparam int REG_W     = 8;
    localparam int NUM_SRC   = 4;
    localparam int SYNC_DEPTH = 2;
    localparam logic [ADDR_W-1:0] REG_ADDR = 12'h285;

    // Field layout; positions are software-visible.
    typedef struct packed {
        logic               cold;   // bit 7
        logic               rsv6;   // bit 6
        logic               nolog;  // bit 5
        logic               rsv4;   // bit 4
        logic [NUM_SRC-1:0] src;    // 3 mgmt, 2 panel, 1 backplane, 0 watchdog
    } rsr_reg_t;

    typedef struct packed {
        logic             hit;
        logic [REG_W-1:0] data;
    } rsr_wr_t;

    function automatic rsr_reg_t rsr_por_value();
        rsr_reg_t v;
        v       = '0;
        v.cold  = 1'b1;
        return v;
    endfunction

    function automatic rsr_reg_t rsr_scrub(rsr_reg_t v);
        rsr_reg_t o;
        o      = v;
        o.rsv6 = 1'b0;
        o.rsv4 = 1'b0;
        return o;
    endfunction
endpackage

// File: rtl/rsr_event_sync.sv
module rsr_event_sync #(
    parameter int NUM_SRC    = rsr_pkg::NUM_SRC,
    parameter int SYNC_DEPTH = rsr_pkg::SYNC_DEPTH
) (
    input  logic               clk,
    input  logic               por_rst,
    input  logic [NUM_SRC-1:0] evt_in,
    output logic [NUM_SRC-1:0] evt_pulse
);
    localparam int CHAIN = SYNC_DEPTH + 1;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic [CHAIN-1:0] chain_q;

        always_ff @(posedge clk) begin
            if (por_rst) chain_q <= '0;
            else         chain_q <= {chain_q[CHAIN-2:0], evt_in[g]};
        end

        assign evt_pulse[g] = chain_q[SYNC_DEPTH-1] & ~chain_q[SYNC_DEPTH];

        // R4
        pulse_single_chk: assert property (@(posedge clk) disable iff (por_rst)
            evt_pulse[g] |=> !evt_pulse[g]);
    end
endmodule

// File: rtl/rsr_bus_port.sv
module rsr_bus_port
    import rsr_pkg::*;
#(
    parameter int ADDR_W = rsr_pkg::ADDR_W,
    parameter int REG_W  = rsr_pkg::REG_W,
    parameter logic [ADDR_W-1:0] DEC_ADDR = rsr_pkg::REG_ADDR
) (
    input  logic              clk,
    input  logic              por_rst,
    input  logic              warm_rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic [REG_W-1:0]  reg_value,
    output rsr_wr_t           wr_req,
    output logic [REG_W-1:0]  bus_rdata
);
    logic sel;
    assign sel = (bus_addr == DEC_ADDR);

    always_comb begin
        wr_req.hit  = sel & bus_wr;
        wr_req.data = bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (por_rst || warm_rst) bus_rdata <= '0;
        else if (sel)            bus_rdata <= reg_value;
        else                     bus_rdata <= '0;
    end

    // R1
    miss_read_chk: assert property (@(posedge clk) disable iff (por_rst)
        !sel |=> (bus_rdata == '0));
    // R9
    warm_rd_chk: assert property (@(posedge clk) disable iff (por_rst)
        warm_rst |=> (bus_rdata == '0));
endmodule

// File: rtl/rsr_flags.sv
module rsr_flags
    import rsr_pkg::*;
#(
    parameter int NUM_SRC = rsr_pkg::NUM_SRC
) (
    input  logic               clk,
    input  logic               por_rst,
    input  logic [NUM_SRC-1:0] evt_pulse,
    input  rsr_wr_t            wr_req,
    output rsr_reg_t           reg_q
);
    rsr_reg_t wv;
    rsr_reg_t nxt;

    assign wv = rsr_reg_t'(wr_req.data);

    always_comb begin
        nxt = reg_q;
        if (wr_req.hit) begin
            nxt.cold  = reg_q.cold & ~wv.cold;
            nxt.nolog = wv.nolog;
            nxt.rsv6  = wv.rsv6;
            nxt.rsv4  = wv.rsv4;
            nxt.src   = reg_q.src & ~wv.src;
        end
        nxt.src = nxt.src | evt_pulse;
        nxt     = rsr_scrub(nxt);
    end

    always_ff @(posedge clk) begin
        if (por_rst) reg_q <= rsr_por_value();
        else         reg_q <= nxt;
    end

    // R2
    por_default_chk: assert property (@(posedge clk)
        por_rst |=> (reg_q == rsr_por_value()));
    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (por_rst)
        (|evt_pulse) |=> ((reg_q.src & $past(evt_pulse)) == $past(evt_pulse)));
    // R5
    w1c_chk: assert property (@(posedge clk) disable iff (por_rst)
        wr_req.hit |=> ((reg_q.src & $past(wv.src & ~evt_pulse)) == '0));
    // R9
    sticky_chk: assert property (@(posedge clk) disable iff (por_rst)
        (!wr_req.hit && evt_pulse == '0) |=> $stable(reg_q));
    // R3
    cold_no_set_chk: assert property (@(posedge clk) disable iff (por_rst)
        !reg_q.cold |=> !reg_q.cold);
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
    import rsr_pkg::*;
(
    input  logic              clk,
    input  logic              por_rst,
    input  logic              warm_rst,
    input  logic              evt_mgmt,
    input  logic              evt_panel,
    input  logic              evt_bkpl,
    input  logic              evt_wdog,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata
);
    logic [NUM_SRC-1:0] evt_raw;
    logic [NUM_SRC-1:0] evt_pulse;
    rsr_wr_t            wr_req;
    rsr_reg_t           reg_q;

    assign evt_raw = {evt_mgmt, evt_panel, evt_bkpl, evt_wdog};

    rsr_event_sync #(.NUM_SRC(NUM_SRC), .SYNC_DEPTH(SYNC_DEPTH)) u_sync (
        .clk       (clk),
        .por_rst   (por_rst),
        .evt_in    (evt_raw),
        .evt_pulse (evt_pulse)
    );

    rsr_flags #(.NUM_SRC(NUM_SRC)) u_flags (
        .clk       (clk),
        .por_rst   (por_rst),
        .evt_pulse (evt_pulse),
        .wr_req    (wr_req),
        .reg_q     (reg_q)
    );

    rsr_bus_port #(.ADDR_W(ADDR_W), .REG_W(REG_W), .DEC_ADDR(REG_ADDR)) u_bus (
        .clk       (clk),
        .por_rst   (por_rst),
        .warm_rst  (warm_rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .reg_value (reg_q),
        .wr_req    (wr_req),
        .bus_rdata (bus_rdata)
    );
endmodule

// File: tb/rst_cause_reg_bench.sv
module rst_cause_reg_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 20000;
    localparam logic [11:0] RADDR = 12'h285;

    logic clk = 1'b0;
    logic por_rst = 1'b1, warm_rst = 1'b0;
    logic evt_mgmt = 0, evt_panel = 0, evt_bkpl = 0, evt_wdog = 0;
    logic [11:0] bus_addr = RADDR;
    logic bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;

    int errors = 0, checks = 0, cyc = 0;
    string phase = "R2";

    // reference model state
    logic [7:0] m_reg = 8'h80;
    logic [3:0] h1 = 0, h2 = 0, h3 = 0;
    logic [7:0] exp_rd = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    rst_cause_reg u_rst_cause_reg (
        .clk(clk), .por_rst(por_rst), .warm_rst(warm_rst),
        .evt_mgmt(evt_mgmt), .evt_panel(evt_panel), .evt_bkpl(evt_bkpl), .evt_wdog(evt_wdog),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT) begin
            errors++;
            $display("FAIL watchdog: act=%0d cycles exp<%0d", cyc, WD_LIMIT);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic model_edge();
        logic [3:0] ev, p;
        logic [7:0] nm;
        ev = {evt_mgmt, evt_panel, evt_bkpl, evt_wdog};
        if (por_rst) begin
            m_reg = 8'h80; h1 = 0; h2 = 0; h3 = 0; exp_rd = 8'h00;
        end else begin
            exp_rd = (warm_rst || bus_addr != RADDR) ? 8'h00 : m_reg;
            p  = h2 & ~h3;
            h3 = h2; h2 = h1; h1 = ev;
            nm = m_reg;
            if (bus_wr && bus_addr == RADDR) begin
                if (bus_wdata[7]) nm[7] = 1'b0;
                nm[5]   = bus_wdata[5];
                nm[3:0] = m_reg[3:0] & ~bus_wdata[3:0];
            end
            nm[3:0] = nm[3:0] | p;
            nm[6] = 1'b0; nm[4] = 1'b0;
            m_reg = nm;
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        checks++;
        if (bus_rdata !== exp_rd) begin
            errors++;
            $display("FAIL %s cycle model: act=%h exp=%h", phase, bus_rdata, exp_rd);
        end
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic expect_rd(input string req, input logic [7:0] exp);
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h", req, bus_rdata, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        step();
        bus_wr = 1'b0; bus_wdata = 8'h00; bus_addr = RADDR;
    endtask

    initial begin
        // R2: power-on defaults
        phase = "R2";
        steps(2);
        por_rst = 1'b0;
        step();
        expect_rd("R2", 8'h80);

        // R9: warm reset keeps contents, clears read data
        phase = "R9";
        warm_rst = 1'b1; step();
        expect_rd("R9", 8'h00);
        warm_rst = 1'b0; steps(2);
        expect_rd("R9", 8'h80);

        // R7: firmware flag
        phase = "R7";
        wr(RADDR, 8'h20); step();
        expect_rd("R7", 8'hA0);

        // R8: reserved bits ignore writes
        phase = "R8";
        wr(RADDR, 8'h70); step();
        expect_rd("R8", 8'hA0);

        // R3: cold flag write-one-to-clear
        phase = "R3";
        wr(RADDR, 8'hA0); step();
        expect_rd("R3", 8'h20);

        // R4: each source sets its own bit
        phase = "R4";
        evt_wdog = 1'b1; steps(4);
        expect_rd("R4", 8'h21);
        evt_mgmt = 1'b1; steps(4);
        expect_rd("R4", 8'h29);
        evt_panel = 1'b1; steps(4);
        expect_rd("R4", 8'h2D);
        evt_bkpl = 1'b1; steps(4);
        expect_rd("R4", 8'h2F);
        // held level must not re-set a cleared flag
        wr(RADDR, 8'h21); steps(5);
        expect_rd("R4", 8'h2E);
        evt_wdog = 0; evt_mgmt = 0; evt_panel = 0; evt_bkpl = 0;
        steps(4);

        // R5: zeros do nothing, several clears at once
        phase = "R5";
        wr(RADDR, 8'h20); step();
        expect_rd("R5", 8'h2E);
        wr(RADDR, 8'h26); step();
        expect_rd("R5", 8'h28);
        wr(RADDR, 8'h28); step();
        expect_rd("R5", 8'h20);

        // R6: set beats clear on the same edge
        phase = "R6";
        evt_mgmt = 1'b1;
        steps(2);
        wr(RADDR, 8'h28);
        step();
        expect_rd("R6", 8'h28);
        evt_mgmt = 1'b0; steps(4);

        // R10 and R1: other addresses
        phase = "R10";
        wr(12'h284, 8'hFF);
        bus_addr = 12'h284; step();
        expect_rd("R1", 8'h00);
        bus_addr = RADDR; step();
        expect_rd("R10", 8'h28);

        // R2: power-on again after activity
        phase = "R2";
        por_rst = 1'b1; step();
        por_rst = 1'b0; step();
        expect_rd("R2", 8'h80);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule